// File: doc/BRIEF.md
# Audio Serial Receive Deserializer

This block turns a serial audio stream into parallel words. It takes three slow inputs: a bit clock, a frame clock that tells left from right, and a data line. The bit and frame clocks may come from a local clock generator or from an external master. All three inputs are brought into the system clock domain through a short synchronizer chain. The bit clock is then edge-detected, and every qualifying edge samples one data bit together with the frame clock level.

A change of frame clock level marks the start of a word. Depending on the alignment setting, the first data bit comes on the same sampling edge as the change or on the next one. Bits are shifted in most significant first until 16, 24 or 32 have been collected. The completed word then appears right-justified on a parallel output with a channel flag and a one-cycle valid strobe. Any further bits before the next frame change are dropped. This includes the case where the bit clock simply stops for the unused part of a 24-bit slot. Software-visible registers, buffering and DMA are left to the surrounding logic.

Top module: `aud_ser_rx`

## Requirements
- R1: While `rst_n` is low and after its release, `word_valid` is 0, `word_data` is 0 and `word_chan` is 0 until a word completes.
- R2: With `cfg_fall_edge`=0 bits are sampled on the rising bit-clock edge; with `cfg_fall_edge`=1 on the falling edge; data changes seen only at the other edge have no effect on the captured word.
- R3: With `cfg_delay`=0, the bit sampled at the first sampling edge where the frame clock level differs from the level at the previous sampling edge is the word's most significant bit.
- R4: With `cfg_delay`=1, the most significant bit is the bit sampled at the sampling edge immediately after the one where the frame clock change was seen; the bit at the change edge is not part of the word.
- R5: `cfg_len` selects the word length: 2'b00 = 16 bits, 2'b01 = 24 bits, 2'b10 and 2'b11 = 32 bits. Bits are taken most significant first, the word is right-justified in `word_data`, and bits above the length are 0.
- R6: Bits sampled after the word length is reached and before the next frame clock change are discarded, so exactly one word is produced per frame clock half.
- R7: `word_chan` is 0 for left and 1 for right. With `cfg_swap`=0 a low frame level is left and a high level is right; with `cfg_swap`=1 the mapping is reversed.
- R8: `word_valid` is a single system-clock pulse. It is visible after the third rising system-clock edge that follows the change of `bclk_in` that samples the last bit. `word_data` and `word_chan` hold their values until the next pulse.
- R9: A 24-bit word completes on its 24th sampled bit even if the bit clock then stops for the rest of the slot; the idle gap produces no extra word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the serial inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Serial bit clock |
| fclk_in | input | 1 | Frame (left/right) clock |
| sdata_in | input | 1 | Serial data line |
| cfg_len | input | 2 | Word length select (00=16, 01=24, 1x=32) |
| cfg_fall_edge | input | 1 | 1 = sample on falling bit-clock edge, 0 = rising |
| cfg_delay | input | 1 | 1 = first bit one bit-clock after the frame change |
| cfg_swap | input | 1 | 1 = high frame level is the left channel |
| word_data | output | 32 | Completed word, right-justified |
| word_chan | output | 1 | Channel of the word, 0 = left, 1 = right |
| word_valid | output | 1 | One-cycle strobe marking a new word |

## Verification
A word appears three system clocks after the bench moves the bit clock to the sampling level for the final bit: two synchronizer stages, then one register that updates the shifter and output. The bench records the cycle of every sampling edge it drives and the cycle of every valid strobe. It requires the difference to be exactly three, and it samples outputs on the falling system-clock edge so that each reading falls inside the expected cycle. Data is changed a few system clocks after the non-sampling edge, so sampling on the wrong edge would capture stale bits.

// File: rtl/aud_ser_rx_pkg.sv
package aud_ser_rx_pkg;

    localparam int MAX_W = 32;
    localparam int CNT_W = $clog2(MAX_W + 1);

    typedef enum logic [1:0] {
        LEN_16  = 2'b00,
        LEN_24  = 2'b01,
        LEN_32  = 2'b10,
        LEN_32X = 2'b11
    } len_sel_e;

    typedef struct packed {
        logic             active;
        logic             pend;
        logic             f_last;
        logic [CNT_W-1:0] cnt;
        logic [MAX_W-1:0] sh;
        logic             chan;
        logic [MAX_W-1:0] out;
        logic             out_chan;
        logic             vld;
    } core_st_t;

    function automatic logic [CNT_W-1:0] len_bits(input logic [1:0] sel);
        case (len_sel_e'(sel))
            LEN_16:  len_bits = CNT_W'(16);
            LEN_24:  len_bits = CNT_W'(24);
            default: len_bits = CNT_W'(MAX_W);
        endcase
    endfunction

endpackage

// File: rtl/aud_ser_sync.sv
module aud_ser_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    for (genvar s = 0; s < STAGES; s++) begin : g_stg
        logic [WIDTH-1:0] stage_q;
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= g_stg[s-1].stage_q;
            end
        end
    end

    assign dout = g_stg[STAGES-1].stage_q;

endmodule

// File: rtl/aud_ser_edge.sv
module aud_ser_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_s,
    input  logic fall_sel,
    output logic samp
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = bclk_s;
        if (fall_sel) samp = prev_q & ~bclk_s;
        else          samp = ~prev_q & bclk_s;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

endmodule

// File: rtl/aud_ser_shift.sv
module aud_ser_shift
    import aud_ser_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp,
    input  logic             d_s,
    input  logic             f_s,
    input  logic [1:0]       cfg_len,
    input  logic             cfg_delay,
    input  logic             cfg_swap,
    output logic [MAX_W-1:0] word_data,
    output logic             word_chan,
    output logic             word_valid
);

    core_st_t st_d, st_q;
    logic     fchg;
    logic     start;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        fchg     = f_s ^ st_q.f_last;
        start    = cfg_delay ? st_q.pend : fchg;
        if (samp) begin
            st_d.f_last = f_s;
            st_d.pend   = fchg;
            if (start) begin
                // A new word restarts capture whatever was in progress
                st_d.active = 1'b1;
                st_d.cnt    = CNT_W'(1);
                st_d.sh     = {{(MAX_W-1){1'b0}}, d_s};
                st_d.chan   = f_s ^ cfg_swap;
            end else if (st_q.active) begin
                st_d.sh  = {st_q.sh[MAX_W-2:0], d_s};
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
            if (st_d.active && (st_d.cnt == len_bits(cfg_len))) begin
                st_d.out      = st_d.sh;
                st_d.out_chan = st_d.chan;
                st_d.vld      = 1'b1;
                st_d.active   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_data  = st_q.out;
    assign word_chan  = st_q.out_chan;
    assign word_valid = st_q.vld;

endmodule

// File: rtl/aud_ser_rx.sv
module aud_ser_rx
    import aud_ser_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bclk_in,
    input  logic        fclk_in,
    input  logic        sdata_in,
    input  logic [1:0]  cfg_len,
    input  logic        cfg_fall_edge,
    input  logic        cfg_delay,
    input  logic        cfg_swap,
    output logic [31:0] word_data,
    output logic        word_chan,
    output logic        word_valid
);

    localparam int NUM_IN = 3;

    logic [NUM_IN-1:0] raw_in;
    logic [NUM_IN-1:0] sync_in;
    logic              samp_stb;

    assign raw_in = {bclk_in, fclk_in, sdata_in};

    aud_ser_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (sync_in)
    );

    aud_ser_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .bclk_s  (sync_in[2]),
        .fall_sel(cfg_fall_edge),
        .samp    (samp_stb)
    );

    aud_ser_shift u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp      (samp_stb),
        .d_s       (sync_in[0]),
        .f_s       (sync_in[1]),
        .cfg_len   (cfg_len),
        .cfg_delay (cfg_delay),
        .cfg_swap  (cfg_swap),
        .word_data (word_data),
        .word_chan (word_chan),
        .word_valid(word_valid)
    );

endmodule

// File: rtl/aud_ser_rx_chk.sv
module aud_ser_rx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        samp,
    input logic [1:0]  cfg_len,
    input logic [31:0] word_data,
    input logic        word_chan,
    input logic        word_valid
);

    p_valid_follows_sample_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(samp));

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    p_hold_between_words_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> ($stable(word_data) && $stable(word_chan)));

    p_len16_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && cfg_len == 2'b00) |-> (word_data[31:16] == 16'h0));

    p_len24_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && cfg_len == 2'b01) |-> (word_data[31:24] == 8'h0));

endmodule

bind aud_ser_rx aud_ser_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp      (samp_stb),
    .cfg_len   (cfg_len),
    .word_data (word_data),
    .word_chan (word_chan),
    .word_valid(word_valid)
);

// File: tb/aud_ser_rx_bench.sv
`timescale 1ns/1ps
module aud_ser_rx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_in = 1'b0;
    logic        fclk_in = 1'b0;
    logic        sdata_in = 1'b0;
    logic [1:0]  cfg_len = 2'b00;
    logic        cfg_fall_edge = 1'b0;
    logic        cfg_delay = 1'b0;
    logic        cfg_swap = 1'b0;
    logic [31:0] word_data;
    logic        word_chan;
    logic        word_valid;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int last_samp = 0;
    int cap_n = 0;
    int base = 0;
    int pulse_err = 0;
    bit prev_v = 1'b0;
    bit done = 1'b0;
    logic [31:0] cap_word [16];
    logic        cap_chan [16];
    int          cap_lat  [16];

    aud_ser_rx u_aud_ser_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .bclk_in      (bclk_in),
        .fclk_in      (fclk_in),
        .sdata_in     (sdata_in),
        .cfg_len      (cfg_len),
        .cfg_fall_edge(cfg_fall_edge),
        .cfg_delay    (cfg_delay),
        .cfg_swap     (cfg_swap),
        .word_data    (word_data),
        .word_chan    (word_chan),
        .word_valid   (word_valid)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && word_valid) begin
            if (cap_n < 16) begin
                cap_word[cap_n] = word_data;
                cap_chan[cap_n] = word_chan;
                cap_lat[cap_n]  = cyc - last_samp;
            end
            cap_n = cap_n + 1;
        end
        if (rst_n && word_valid && prev_v) pulse_err = pulse_err + 1;
        prev_v = word_valid;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] len, input bit fall, input bit dly, input bit swp);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_len = len;
        cfg_fall_edge = fall;
        cfg_delay = dly;
        cfg_swap = swp;
        bclk_in = fall;
        fclk_in = 1'b0;
        sdata_in = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        base = cap_n;
    endtask

    task automatic bit_tx(input bit f, input bit d);
        bclk_in = cfg_fall_edge;
        repeat (2) @(negedge clk);
        fclk_in = f;
        sdata_in = d;
        repeat (2) @(negedge clk);
        bclk_in = ~cfg_fall_edge;
        last_samp = cyc;
        repeat (4) @(negedge clk);
    endtask

    task automatic slot_tx(input bit lvl, input logic [31:0] w, input int len, input int pad);
        int dl;
        dl = cfg_delay ? 1 : 0;
        for (int j = 0; j < len + dl + pad; j++) begin
            int idx;
            idx = j - dl;
            if (idx >= 0 && idx < len) bit_tx(lvl, w[len-1-idx]);
            else                       bit_tx(lvl, 1'b1);
        end
    endtask

    task automatic run_pair(input string tag, input logic [1:0] sel, input int len, input bit fall,
                            input bit dly, input bit swp, input logic [31:0] lw,
                            input logic [31:0] rw, input int pad, input bit gated);
        int pe0;
        do_reset(sel, fall, dly, swp);
        pe0 = pulse_err;
        bit_tx(~swp, 1'b1);
        slot_tx(swp, lw, len, pad);
        if (gated) repeat (64) @(negedge clk);
        slot_tx(~swp, rw, len, pad);
        if (gated) repeat (64) @(negedge clk);
        repeat (8) @(negedge clk);
        chk(cap_n - base == 2, {tag, " R6 word count"}, 32'(cap_n - base), 32'd2);
        if (cap_n - base >= 2) begin
            chk(cap_word[base] == lw, {tag, " R5 left word"}, cap_word[base], lw);
            chk(cap_chan[base] == 1'b0, {tag, " R7 left chan"}, 32'(cap_chan[base]), 32'd0);
            chk(cap_word[base+1] == rw, {tag, " R5 right word"}, cap_word[base+1], rw);
            chk(cap_chan[base+1] == 1'b1, {tag, " R7 right chan"}, 32'(cap_chan[base+1]), 32'd1);
            chk(cap_lat[base] == 3 && cap_lat[base+1] == 3, {tag, " R8 latency"},
                32'(cap_lat[base]), 32'd3);
        end
        chk(pulse_err == pe0, {tag, " R8 single pulse"}, 32'(pulse_err - pe0), 32'd0);
    endtask

    task automatic t_reset;
        do_reset(2'b00, 1'b0, 1'b0, 1'b0);
        chk(word_valid == 1'b0, "R1 valid after reset", 32'(word_valid), 32'd0);
        chk(word_data == 32'h0, "R1 data after reset", word_data, 32'h0);
        chk(word_chan == 1'b0, "R1 chan after reset", 32'(word_chan), 32'd0);
    endtask

    initial begin
        t_reset();
        // R2 R3 R6: rising edge, same-cycle alignment, long discarded tail
        run_pair("T16", 2'b00, 16, 1'b0, 1'b0, 1'b0, 32'h0000A5C3, 32'h00001234, 16, 1'b0);
        // R2 R4: falling edge, delayed alignment
        run_pair("T24", 2'b01, 24, 1'b1, 1'b1, 1'b0, 32'h00C3A581, 32'h007E0142, 4, 1'b0);
        // R4 R7: swapped channel polarity
        run_pair("T32", 2'b10, 32, 1'b0, 1'b1, 1'b1, 32'hDEADBEEF, 32'h80000001, 2, 1'b0);
        // R9: bit clock stops after the 24th bit
        run_pair("T24G", 2'b01, 24, 1'b1, 1'b0, 1'b0, 32'h00F00F5A, 32'h00800001, 0, 1'b1);
        // R5: code 11 also selects 32 bits
        run_pair("T32X", 2'b11, 32, 1'b1, 1'b0, 1'b1, 32'h13579BDF, 32'hFEDCBA98, 0, 1'b0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests = tests + 1;
            fails = fails + 1;
            $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule